// File: doc/BRIEF.md
# Variable-Length CAN Message Receive FIFO

This block holds accepted CAN messages in a circular byte store so that a host can work on one message while later ones keep arriving. Each message occupies a two-byte descriptor (identifier, remote flag, data length code) followed by zero to eight data bytes. The number of messages that fit therefore depends on their lengths. The receiver side opens a frame, pushes its bytes one at a time, and then either declares the frame valid or reports an error. A valid frame is committed as a whole, and an errored frame is rolled back as a whole.

The host reads through a fixed window of thirteen byte addresses. The window always starts at the oldest message still held, and its addresses wrap around the end of the store. A release command frees that message and moves the window to the next one. Two other conditions are flagged. A frame that ran out of space but later became valid raises a sticky overrun flag. The message-available flag drops on every release and comes back on the next bit-quantum tick if more messages remain.

A hardware reset returns both pointers to address 0. A software or bus-off reset empties the store but keeps the current start address, and the next frame is written there.

Top module: `msg_rx_fifo`

## Requirements
- R1: After hardware reset, msg_cnt is 0, has_msg and ovr_flag are 0, and win_base is 0.
- R2: In descriptor byte 1, bit 4 is the remote flag and bits [3:0] are the length code. A stored message is 2 bytes long if the remote flag is set. Otherwise it is 2 + min(code, 8) bytes. Bytes pushed beyond that length are ignored.
- R3: Window address a in 0..12 reads the stored byte at (win_base + a) mod DEPTH. Addresses 13 to 15 read 0.
- R4: frm_ok on a complete frame commits it. In the next cycle msg_cnt has risen by 1, has_msg is 1, and the message can be read in the window in arrival order.
- R5: Free space is checked before each byte is pushed. A byte that arrives when committed bytes plus the bytes already in the frame equal DEPTH discards the whole frame. ovr_flag is then set only if frm_ok ends that frame. clr_ovr clears the flag, and a new overrun wins over clr_ovr in the same cycle.
- R6: msg_cnt rises only on frm_ok and never exceeds DEPTH/2.
- R7: frm_err, an incomplete frm_ok, or a new frm_start discards the open frame. Its space is reused and no overrun is flagged.
- R8: rel_cmd on a non-empty store does three things: it advances win_base by the message length, lowers msg_cnt by 1, and drops has_msg in the next cycle. has_msg returns on the next tq_tick if messages remain. rel_cmd on an empty store changes nothing.
- R9: soft_rst clears msg_cnt, has_msg and ovr_flag and keeps win_base. The next frame is read back starting at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Software or bus-off reset |
| frm_start | input | 1 | Opens a new frame |
| byte_we | input | 1 | Pushes byte_in into the open frame |
| byte_in | input | 8 | Frame byte |
| frm_ok | input | 1 | Frame became valid |
| frm_err | input | 1 | Frame failed with an error |
| rel_cmd | input | 1 | Release the oldest message |
| clr_ovr | input | 1 | Clear the overrun flag |
| tq_tick | input | 1 | Bit-quantum strobe |
| win_addr | input | 4 | Read window offset |
| win_data | output | 8 | Byte at the window offset |
| has_msg | output | 1 | At least one message is available |
| ovr_flag | output | 1 | Overrun since the last clear |
| msg_cnt | output | 7 | Messages stored |
| win_base | output | 6 | Store address of the oldest message |

## Verification
The bench builds the block with its defaults, a 64-byte store and a 13-byte window. At that size an exact fill takes seven frames, so the exact-fill case and the one-byte-over case are both cheap to reach. A few hundred random operations also carry win_base around the wrap point several times, which exercises window reads that straddle the end of the store. Random length codes above 8, remote frames, trailing junk bytes and mid-frame errors test the length rules and the rollback against a byte-queue model.

// File: rtl/msg_rx_fifo.sv
module msg_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIN   = 13,
  localparam int AW   = $clog2(DEPTH),
  localparam int WAW  = $clog2(WIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           frm_start,
  input  logic           byte_we,
  input  logic [7:0]     byte_in,
  input  logic           frm_ok,
  input  logic           frm_err,
  input  logic           rel_cmd,
  input  logic           clr_ovr,
  input  logic           tq_tick,
  input  logic [WAW-1:0] win_addr,
  output logic [7:0]     win_data,
  output logic           has_msg,
  output logic           ovr_flag,
  output logic [AW:0]    msg_cnt,
  output logic [AW-1:0]  win_base
);

  function automatic logic [3:0] mlen(input logic [7:0] h);
    if (h[4])             mlen = 4'd2;
    else if (h[3:0] > 4'd8) mlen = 4'd10;
    else                  mlen = h[3:0] + 4'd2;
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, fbase;
  logic [AW:0]   used, cnt;
  logic [3:0]    fcnt;
  logic          in_frm, drop, rbs, ovr;

  logic [3:0] flen, rlen;
  logic       byte_try, room, byte_ok, commit, ovr_evt, do_rel;

  assign flen     = mlen(mem[fbase + AW'(1)]);
  assign rlen     = mlen(mem[rd_ptr + AW'(1)]);
  assign byte_try = in_frm && !drop && byte_we && !frm_start &&
                    (fcnt < 4'd2 || fcnt < flen);
  assign room     = (used + (AW+1)'(fcnt)) < (AW+1)'(DEPTH);
  assign byte_ok  = byte_try && room;
  assign commit   = in_frm && frm_ok && !drop && !frm_start &&
                    fcnt >= 4'd2 && fcnt == flen;
  assign ovr_evt  = in_frm && frm_ok && drop && !frm_start;
  assign do_rel   = rel_cmd && cnt != '0;

  always_ff @(posedge clk)
    if (byte_ok && !soft_rst)
      mem[fbase + AW'(fcnt)] <= byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      fbase  <= '0;
      used   <= '0;
      cnt    <= '0;
      fcnt   <= '0;
      in_frm <= 1'b0;
      drop   <= 1'b0;
      rbs    <= 1'b0;
      ovr    <= 1'b0;
    end else if (soft_rst) begin
      fbase  <= rd_ptr;
      used   <= '0;
      cnt    <= '0;
      fcnt   <= '0;
      in_frm <= 1'b0;
      drop   <= 1'b0;
      rbs    <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      used <= used + (commit ? (AW+1)'(fcnt) : '0) - (do_rel ? (AW+1)'(rlen) : '0);
      cnt  <= cnt + (commit ? (AW+1)'(1) : '0) - (do_rel ? (AW+1)'(1) : '0);
      if (do_rel) rd_ptr <= rd_ptr + AW'(rlen);

      if (frm_start) begin
        in_frm <= 1'b1;
        drop   <= 1'b0;
        fcnt   <= '0;
      end else if (in_frm && (frm_ok || frm_err)) begin
        in_frm <= 1'b0;
        drop   <= 1'b0;
        fcnt   <= '0;
        if (commit) fbase <= fbase + AW'(fcnt);
      end else if (byte_try) begin
        if (room) fcnt <= fcnt + 4'd1;
        else begin
          drop <= 1'b1;
          fcnt <= '0;
        end
      end

      if (rel_cmd)                       rbs <= 1'b0;
      else if (commit)                   rbs <= 1'b1;
      else if (tq_tick && cnt != '0)     rbs <= 1'b1;

      if (ovr_evt)      ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end

  assign win_data = (32'(win_addr) < WIN) ? mem[rd_ptr + AW'(win_addr)] : 8'h00;
  assign has_msg  = rbs;
  assign ovr_flag = ovr;
  assign msg_cnt  = cnt;
  assign win_base = rd_ptr;

endmodule

// File: rtl/msg_rx_fifo_chk.sv
module msg_rx_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_ok,
  input logic          rel_cmd,
  input logic          has_msg,
  input logic          ovr_flag,
  input logic [AW:0]   msg_cnt,
  input logic [AW-1:0] win_base
);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    msg_cnt <= (AW+1)'(DEPTH/2));

  a_r6_count_rise_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_cnt > $past(msg_cnt)) |-> $past(frm_ok));

  a_r8_empty_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_cnt == '0) |-> !has_msg);

  a_r8_release_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cmd |=> !has_msg);

  a_r5_overrun_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(frm_ok));

  a_r9_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_cmd |=> $stable(win_base));

endmodule

bind msg_rx_fifo msg_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .rel_cmd(rel_cmd),
  .has_msg(has_msg), .ovr_flag(ovr_flag), .msg_cnt(msg_cnt), .win_base(win_base)
);

// File: tb/tb_msg_rx_fifo.sv
module tb_msg_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0, soft_rst = 0, frm_start = 0, byte_we = 0;
  logic frm_ok = 0, frm_err = 0, rel_cmd = 0, clr_ovr = 0, tq_tick = 0;
  logic [7:0] byte_in = 0;
  logic [3:0] win_addr = 0;
  logic [7:0] win_data;
  logic has_msg, ovr_flag;
  logic [6:0] msg_cnt;
  logic [5:0] win_base;

  msg_rx_fifo dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mq[$];
  int lq[$];
  int m_used = 0, m_base = 0;
  bit m_ovr = 0, m_rbs = 0;

  function automatic int exp_len(logic rtr, logic [3:0] dlc);
    if (rtr) return 2;
    return 2 + ((dlc > 8) ? 8 : int'(dlc));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(msg_cnt == 7'(lq.size()), {req, " count"}, msg_cnt, lq.size());
    chk(has_msg == m_rbs, {req, " has_msg"}, has_msg, m_rbs);
    chk(ovr_flag == m_ovr, {req, " ovr"}, ovr_flag, m_ovr);
    chk(win_base == 6'(m_base), {req, " base"}, win_base, m_base);
    if (lq.size() > 0)
      for (int k = 0; k < lq[0]; k++) begin
        win_addr = 4'(k);
        #1;
        chk(win_data == mq[k], {req, " R3 window"}, win_data, mq[k]);
      end
  endtask

  task automatic send_frame(logic [10:0] id, logic rtr, logic [3:0] dlc,
                            int extra, int err_at);
    int len = exp_len(rtr, dlc);
    logic [7:0] b[$];
    b.push_back(id[10:3]);
    b.push_back({id[2:0], rtr, dlc});
    for (int i = 2; i < len + extra; i++) b.push_back(8'($urandom));
    @(negedge clk) frm_start = 1;
    @(negedge clk) frm_start = 0;
    for (int i = 0; i < b.size(); i++) begin
      if (err_at >= 0 && i >= err_at) break;
      byte_we = 1; byte_in = b[i];
      @(negedge clk);
    end
    byte_we = 0;
    if (err_at >= 0) frm_err = 1; else frm_ok = 1;
    @(negedge clk) begin frm_ok = 0; frm_err = 0; end
    if (err_at < 0) begin
      if (m_used + len > DEPTH) m_ovr = 1;
      else begin
        for (int i = 0; i < len; i++) mq.push_back(b[i]);
        lq.push_back(len);
        m_used += len;
        m_rbs = 1;
      end
    end
  endtask

  task automatic release_msg();
    @(negedge clk) rel_cmd = 1;
    @(negedge clk) rel_cmd = 0;
    if (lq.size() > 0) begin
      int l = lq.pop_front();
      for (int i = 0; i < l; i++) void'(mq.pop_front());
      m_base = (m_base + l) % DEPTH;
      m_used -= l;
    end
    m_rbs = 0;
  endtask

  task automatic tick();
    @(negedge clk) tq_tick = 1;
    @(negedge clk) tq_tick = 0;
    if (lq.size() > 0) m_rbs = 1;
  endtask

  task automatic clear_ovr();
    @(negedge clk) clr_ovr = 1;
    @(negedge clk) clr_ovr = 0;
    m_ovr = 0;
  endtask

  task automatic do_soft();
    @(negedge clk) soft_rst = 1;
    @(negedge clk) soft_rst = 0;
    mq.delete(); lq.delete();
    m_used = 0; m_rbs = 0; m_ovr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");

    // R2: code above 8 saturates, junk bytes ignored; remote frame is 2 bytes
    send_frame(11'h123, 0, 4'd12, 3, -1);
    check_state("R2 R4 saturate");
    win_addr = 4'd13; #1;
    chk(win_data == 8'h00, "R3 out of window", win_data, 0);
    win_addr = 4'd15; #1;
    chk(win_data == 8'h00, "R3 out of window", win_data, 0);
    send_frame(11'h055, 1, 4'd5, 2, -1);
    check_state("R2 remote");
    release_msg();
    check_state("R8 release");
    tick();
    check_state("R8 tick reset flag");
    release_msg();
    check_state("R8 release last");
    release_msg();
    check_state("R8 release empty");
    tick();
    check_state("R8 tick empty");

    // R5: exact fill, then one more
    for (int i = 0; i < 6; i++) send_frame(11'(i), 0, 4'd8, 0, -1);
    send_frame(11'h7FF, 0, 4'd2, 0, -1);
    check_state("R5 exact fill");
    send_frame(11'h001, 0, 4'd3, 0, 4);
    check_state("R7 error while full");
    send_frame(11'h001, 0, 4'd0, 0, -1);
    check_state("R5 overrun");
    clear_ovr();
    check_state("R5 clear");
    release_msg(); tick();
    send_frame(11'h2AA, 0, 4'd8, 0, -1);
    check_state("R5 R3 wrap fill");

    // R7: error frame then reuse
    release_msg(); tick();
    send_frame(11'h3C3, 0, 4'd8, 0, 5);
    send_frame(11'h3C4, 0, 4'd6, 0, -1);
    check_state("R7 rollback");
    while (lq.size() > 0) begin release_msg(); tick(); check_state("R3 R8 drain"); end

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      if (op < 5)
        send_frame(11'($urandom), ($urandom % 8) == 0, 4'($urandom), $urandom % 3, -1);
      else if (op == 5)
        send_frame(11'($urandom), 0, 4'($urandom % 9), 0, $urandom % 6);
      else if (op < 8) release_msg();
      else if (op == 8) tick();
      else clear_ovr();
      check_state("R4 R5 R6 R7 R8 random");
    end

    // R9: soft reset keeps start address
    while (m_base == 0) begin
      send_frame(11'h010, 0, 4'd1, 0, -1);
      release_msg();
    end
    send_frame(11'h011, 0, 4'd4, 0, -1);
    do_soft();
    check_state("R9 soft reset");
    send_frame(11'h012, 0, 4'd7, 0, -1);
    check_state("R9 after soft reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule